// File: doc/BRIEF.md
# Four-Channel PWM Controller with Trigger-Applied Settings

This block generates four independent pulse-width-modulated outputs from one input clock. Software programs each channel through a small word-addressed register port. Each channel has a period count, a duty count and a 6-bit clock prescaler. A shared control word holds a run bit, an output polarity bit and a drive-style bit for every channel.

The timing values do not reach a channel the moment they are written. Period, duty, prescale and polarity go into holding registers. They are copied into the channel's working registers only when the channel's run bit changes from 0 to 1. Software can therefore rewrite all values of a running channel and then apply them at once: it clears the run bit and sets it again. A channel whose run bit is clear keeps its counters at zero and drives its inactive level.

Each output comes with an output-enable. This lets the pin work either as a push-pull driver or as an open-drain line that only pulls low.

Top module: `qpwm_top`

## Requirements
- R1: The control word at byte address 0x00 holds channel n's run bit at bit n, its polarity bit at bit 8+n and its drive-style bit at bit 15+n (n = 0..3). A read returns these bits as last written and returns zero in every other bit position.
- R2: Channel n's 16-bit period count is at address 0x04+8n and its 16-bit duty count is at address 0x08+8n. Each reads back the low 16 bits last written.
- R3: The prescale word at address 0x24 packs four 6-bit fields. Channel n uses bits (3-n)*6+5 down to (3-n)*6, so channel 0 owns bits 23:18 and channel 3 owns bits 5:0. The word reads back bits 23:0 as written and reads zero above them.
- R4: A running channel with prescale p, period count P (P >= 2) and duty count D repeats every (p+1)*P clock cycles. Each repetition begins with (p+1)*D cycles of the active level. The first active cycle is the second clock cycle after the write edge that sets the run bit.
- R5: A duty count of 0 keeps the output inactive for the whole period. A duty count greater than or equal to the period count keeps it active for the whole period.
- R6: Writing period, duty, prescale or polarity while a channel is running leaves its output waveform unchanged. Those writes only stage values.
- R7: A 0-to-1 change of a channel's run bit applies all staged values for that channel. The run bit needs to be low during only one clock edge between the two control writes for the change to be seen.
- R8: An applied polarity of 1 makes the active level high. An applied polarity of 0 makes the active level low.
- R9: Starting one cycle after a write clears a channel's run bit, the channel drives the inactive level of its applied polarity. Its counters restart from zero on the next apply.
- R10: With drive-style 0 the channel's output-enable is always 1. With drive-style 1 the output-enable is 1 only while the output is low, so the line is released for the high level.
- R11: After reset all registers read zero. Every output is high, because the applied polarity of 0 makes the inactive level high. Every output-enable is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the register port and the PWM counters |
| rstN | input | 1 | Active-low asynchronous reset |
| busValid | input | 1 | Write strobe qualifier for the register port |
| busWrite | input | 1 | 1 selects a write when busValid is high |
| busAddr | input | 6 | Byte address of the register |
| busWdata | input | 32 | Write data |
| busRdata | output | 32 | Read data for busAddr, combinational |
| pwmOut | output | 4 | PWM level, one bit per channel |
| pwmOe | output | 4 | Output-enable for each pin |

## Verification
A wrong working register or a lost apply pulse shows as a pwmOut waveform that differs from the closed-form pattern. The difference appears within one period of (p+1)*P cycles after the trigger. The bench therefore compares every cycle of a window against that formula, both before and after staged writes. A stale counter after a run-bit clear shows as a non-inactive level within two cycles. A corrupted holding register shows up immediately on busRdata.

// File: rtl/qpwm_pkg.sv
package qpwm_pkg;
  localparam int CH_N   = 4;
  localparam int CNT_W  = 16;
  localparam int PRE_W  = 6;
  localparam int ADDR_W = 6;
  localparam int DATA_W = 32;

  // strobes from the register side to the counting side
  typedef struct packed {
    logic [CH_N-1:0] apply; // one-cycle pulse: copy staged values
    logic [CH_N-1:0] run;   // channel counting
  } chStrobe_t;
endpackage

// File: rtl/qpwm_ctrl.sv
module qpwm_ctrl
  import qpwm_pkg::*;
(
  input  logic                        clk,
  input  logic                        rstN,
  input  logic                        busValid,
  input  logic                        busWrite,
  input  logic [ADDR_W-1:0]           busAddr,
  input  logic [DATA_W-1:0]           busWdata,
  output logic [DATA_W-1:0]           busRdata,
  output chStrobe_t                   strb,
  output logic [CH_N-1:0][CNT_W-1:0]  shPeriod,
  output logic [CH_N-1:0][CNT_W-1:0]  shDuty,
  output logic [CH_N-1:0][PRE_W-1:0]  shPre,
  output logic [CH_N-1:0]             shPol,
  output logic [CH_N-1:0]             driveOd
);
  localparam int CTRL_ADDR = 0;
  localparam int PER_BASE  = 4;
  localparam int DUTY_BASE = 8;
  localparam int STRIDE    = 8;
  localparam int PRE_ADDR  = PER_BASE + STRIDE * CH_N;
  localparam int POL_LSB   = 8;
  localparam int DRV_LSB   = 15;
  localparam int PRE_BITS  = CH_N * PRE_W;

  logic                wrEn;
  logic [CH_N-1:0]     enReg;
  logic [CH_N-1:0]     prevEn;
  logic [PRE_BITS-1:0] preRaw;

  assign wrEn = busValid & busWrite;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      enReg   <= '0;
      prevEn  <= '0;
      shPol   <= '0;
      driveOd <= '0;
      preRaw  <= '0;
    end else begin
      prevEn <= enReg;
      if (wrEn && busAddr == ADDR_W'(CTRL_ADDR)) begin
        enReg   <= busWdata[CH_N-1:0];
        shPol   <= busWdata[POL_LSB +: CH_N];
        driveOd <= busWdata[DRV_LSB +: CH_N];
      end
      if (wrEn && busAddr == ADDR_W'(PRE_ADDR))
        preRaw <= busWdata[PRE_BITS-1:0];
    end
  end

  for (genvar g = 0; g < CH_N; g++) begin : gen_stage
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        shPeriod[g] <= '0;
        shDuty[g]   <= '0;
      end else begin
        if (wrEn && busAddr == ADDR_W'(PER_BASE + STRIDE * g))
          shPeriod[g] <= busWdata[CNT_W-1:0];
        if (wrEn && busAddr == ADDR_W'(DUTY_BASE + STRIDE * g))
          shDuty[g] <= busWdata[CNT_W-1:0];
      end
    end
    // channel 0 sits in the most significant field
    assign shPre[g] = preRaw[(CH_N-1-g)*PRE_W +: PRE_W];
  end

  assign strb.apply = enReg & ~prevEn;
  assign strb.run   = prevEn;

  always_comb begin
    busRdata = '0;
    if (busAddr == ADDR_W'(CTRL_ADDR)) begin
      busRdata[CH_N-1:0]         = enReg;
      busRdata[POL_LSB +: CH_N]  = shPol;
      busRdata[DRV_LSB +: CH_N]  = driveOd;
    end
    if (busAddr == ADDR_W'(PRE_ADDR))
      busRdata[PRE_BITS-1:0] = preRaw;
    for (int c = 0; c < CH_N; c++) begin
      if (busAddr == ADDR_W'(PER_BASE + STRIDE * c))
        busRdata[CNT_W-1:0] = shPeriod[c];
      if (busAddr == ADDR_W'(DUTY_BASE + STRIDE * c))
        busRdata[CNT_W-1:0] = shDuty[c];
    end
  end
endmodule

// File: rtl/qpwm_datapath.sv
module qpwm_datapath
  import qpwm_pkg::*;
(
  input  logic                        clk,
  input  logic                        rstN,
  input  chStrobe_t                   strb,
  input  logic [CH_N-1:0][CNT_W-1:0]  shPeriod,
  input  logic [CH_N-1:0][CNT_W-1:0]  shDuty,
  input  logic [CH_N-1:0][PRE_W-1:0]  shPre,
  input  logic [CH_N-1:0]             shPol,
  output logic [CH_N-1:0]             level,
  output logic [CH_N-1:0]             actPol
);
  for (genvar g = 0; g < CH_N; g++) begin : gen_ch
    logic [CNT_W-1:0] perA;
    logic [CNT_W-1:0] dutyA;
    logic [CNT_W-1:0] cnt;
    logic [CNT_W:0]   cntNext;
    logic [PRE_W-1:0] preA;
    logic [PRE_W-1:0] pc;
    logic             polA;
    logic             active;

    assign cntNext = {1'b0, cnt} + (CNT_W+1)'(1);

    // working copies, loaded only by the apply pulse
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        perA  <= '0;
        dutyA <= '0;
        preA  <= '0;
        polA  <= 1'b0;
      end else if (strb.apply[g]) begin
        perA  <= shPeriod[g];
        dutyA <= shDuty[g];
        preA  <= shPre[g];
        polA  <= shPol[g];
      end
    end

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        pc  <= '0;
        cnt <= '0;
      end else if (!strb.run[g]) begin
        pc  <= '0;
        cnt <= '0;
      end else if (pc == preA) begin
        pc <= '0;
        if (cntNext >= {1'b0, perA}) cnt <= '0;
        else                         cnt <= cntNext[CNT_W-1:0];
      end else begin
        pc <= pc + PRE_W'(1);
      end
    end

    assign active    = strb.run[g] && (cnt < dutyA);
    assign level[g]  = polA ? active : ~active;
    assign actPol[g] = polA;
  end
endmodule

// File: rtl/qpwm_top.sv
module qpwm_top
  import qpwm_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              busValid,
  input  logic              busWrite,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [DATA_W-1:0] busWdata,
  output logic [DATA_W-1:0] busRdata,
  output logic [CH_N-1:0]   pwmOut,
  output logic [CH_N-1:0]   pwmOe
);
  chStrobe_t                  strb;
  logic [CH_N-1:0][CNT_W-1:0] shPeriod;
  logic [CH_N-1:0][CNT_W-1:0] shDuty;
  logic [CH_N-1:0][PRE_W-1:0] shPre;
  logic [CH_N-1:0]            shPol;
  logic [CH_N-1:0]            driveOd;
  logic [CH_N-1:0]            level;
  logic [CH_N-1:0]            actPol;
  logic [CH_N-1:0]            runVec;
  logic [CH_N-1:0]            applyVec;

  qpwm_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .busValid(busValid), .busWrite(busWrite),
    .busAddr(busAddr), .busWdata(busWdata), .busRdata(busRdata),
    .strb(strb), .shPeriod(shPeriod), .shDuty(shDuty), .shPre(shPre),
    .shPol(shPol), .driveOd(driveOd)
  );

  qpwm_datapath u_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .shPeriod(shPeriod),
    .shDuty(shDuty), .shPre(shPre), .shPol(shPol),
    .level(level), .actPol(actPol)
  );

  assign runVec   = strb.run;
  assign applyVec = strb.apply;
  assign pwmOut   = level;
  // open-drain style: drive only the low level
  assign pwmOe    = ~driveOd | ~level;
endmodule

// File: rtl/qpwm_checker.sv
module qpwm_checker
  import qpwm_pkg::*;
(
  input logic              clk,
  input logic              rstN,
  input logic              busValid,
  input logic              busWrite,
  input logic [ADDR_W-1:0] busAddr,
  input logic [DATA_W-1:0] busWdata,
  input logic [DATA_W-1:0] busRdata,
  input logic [CH_N-1:0]   pwmOut,
  input logic [CH_N-1:0]   pwmOe,
  input logic [CH_N-1:0]   runVec,
  input logic [CH_N-1:0]   applyVec,
  input logic [CH_N-1:0]   actPol,
  input logic [CH_N-1:0]   driveOd
);
  assert_ctrl_upper_zero_R1: assert property (@(posedge clk) disable iff (!rstN)
    (busAddr == ADDR_W'(0)) |-> (busRdata[DATA_W-1:19] == '0));

  assert_period_readback_R2: assert property (@(posedge clk) disable iff (!rstN)
    ((busValid && busWrite && busAddr == ADDR_W'(4)) ##1 (busAddr == ADDR_W'(4)))
      |-> (busRdata[CNT_W-1:0] == $past(busWdata[CNT_W-1:0])));

  for (genvar g = 0; g < CH_N; g++) begin : gen_chk
    assert_idle_level_R9: assert property (@(posedge clk) disable iff (!rstN)
      !runVec[g] |-> (pwmOut[g] == ~actPol[g]));

    assert_pol_hold_R6: assert property (@(posedge clk) disable iff (!rstN)
      !applyVec[g] |=> $stable(actPol[g]));

    assert_apply_on_rise_R7: assert property (@(posedge clk) disable iff (!rstN)
      applyVec[g] |-> !runVec[g]);

    assert_run_after_apply_R7: assert property (@(posedge clk) disable iff (!rstN)
      applyVec[g] |=> runVec[g]);

    assert_push_pull_oe_R10: assert property (@(posedge clk) disable iff (!rstN)
      !driveOd[g] |-> pwmOe[g]);

    assert_open_drain_low_only_R10: assert property (@(posedge clk) disable iff (!rstN)
      (driveOd[g] && pwmOe[g]) |-> !pwmOut[g]);
  end
endmodule

bind qpwm_top qpwm_checker u_qpwmChk (
  .clk(clk), .rstN(rstN), .busValid(busValid), .busWrite(busWrite),
  .busAddr(busAddr), .busWdata(busWdata), .busRdata(busRdata),
  .pwmOut(pwmOut), .pwmOe(pwmOe), .runVec(runVec), .applyVec(applyVec),
  .actPol(actPol), .driveOd(driveOd)
);

// File: tb/qpwm_top_bench.sv
module qpwm_top_bench;
  localparam int CLK_PERIOD = 10;
  localparam int NVEC = 6;
  // {ch[2], pol[1], pre[6], period[16], duty[16]}
  localparam logic [40:0] VEC [NVEC] = '{
    {2'd0, 1'b1, 6'd0, 16'd5, 16'd2},
    {2'd1, 1'b1, 6'd2, 16'd4, 16'd1},
    {2'd2, 1'b0, 6'd1, 16'd3, 16'd3},
    {2'd3, 1'b1, 6'd0, 16'd2, 16'd0},
    {2'd0, 1'b0, 6'd3, 16'd6, 16'd4},
    {2'd3, 1'b1, 6'd5, 16'd3, 16'd9}
  };

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        busValid = 1'b0;
  logic        busWrite = 1'b0;
  logic [5:0]  busAddr = '0;
  logic [31:0] busWdata = '0;
  logic [31:0] busRdata;
  logic [3:0]  pwmOut;
  logic [3:0]  pwmOe;
  int          total = 0;
  int          bad = 0;
  logic [31:0] ctrlVal = '0;
  logic [31:0] preVal = '0;

  always #(CLK_PERIOD/2) clk = ~clk;

  qpwm_top u_qpwm_top (
    .clk(clk), .rstN(rstN), .busValid(busValid), .busWrite(busWrite),
    .busAddr(busAddr), .busWdata(busWdata), .busRdata(busRdata),
    .pwmOut(pwmOut), .pwmOe(pwmOe)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic busWr(input logic [5:0] a, input logic [31:0] d);
    @(negedge clk);
    busValid = 1'b1; busWrite = 1'b1; busAddr = a; busWdata = d;
    @(negedge clk);
    busValid = 1'b0; busWrite = 1'b0;
  endtask

  task automatic busRd(input logic [5:0] a, output logic [31:0] d);
    busAddr = a;
    #1;
    d = busRdata;
  endtask

  task automatic progCh(input int ch, input int pre, input int per, input int duty);
    busWr(6'(4 + 8*ch), 32'(per));
    busWr(6'(8 + 8*ch), 32'(duty));
    preVal[(3-ch)*6 +: 6] = 6'(pre);
    busWr(6'd36, preVal);
  endtask

  // clear then set the run bit: one edge with the bit low (R7)
  task automatic trig(input int ch, input logic pol);
    ctrlVal[ch] = 1'b0;
    busWr(6'd0, ctrlVal);
    ctrlVal[8+ch] = pol;
    ctrlVal[ch] = 1'b1;
    busWr(6'd0, ctrlVal);
  endtask

  task automatic watchWave(input int ch, input int pre, input int per, input int duty,
                           input logic pol, input int startK, input int n, input string req);
    int errs;
    logic want;
    errs = 0;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      want = ((((startK + i) / (pre + 1)) % per) < duty) ? pol : ~pol;
      if (pwmOut[ch] !== want) errs++;
    end
    chk(req, 32'(errs), 32'd0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    total++; bad++;
    $display("FAIL R4 watchdog actual=running expected=finished");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [31:0] rd;
    int errs;
    logic seenHi, seenLo;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);

    // R11 reset state
    chk("R11 pwmOut", {28'd0, pwmOut}, 32'hF);
    chk("R11 pwmOe", {28'd0, pwmOe}, 32'hF);
    busRd(6'd0, rd);  chk("R11 ctrl", rd, 0);
    busRd(6'd4, rd);  chk("R11 period0", rd, 0);
    busRd(6'd32, rd); chk("R11 duty3", rd, 0);
    busRd(6'd36, rd); chk("R11 prescale", rd, 0);

    // R1 control bit layout
    busWr(6'd0, 32'hFFFF_FFFF);
    busRd(6'd0, rd); chk("R1 ctrl readback", rd, 32'h0007_8F0F);
    busWr(6'd0, 32'h0);
    ctrlVal = '0;

    // R2 count registers
    busWr(6'd28, 32'h0000_FFFF);
    busRd(6'd28, rd); chk("R2 period3 readback", rd, 32'h0000_FFFF);
    busWr(6'd24, 32'h0001_2345);
    busRd(6'd24, rd); chk("R2 duty2 readback", rd, 32'h0000_2345);

    // R3 prescale packing
    busWr(6'd36, 32'hFFAB_CDEF);
    busRd(6'd36, rd); chk("R3 prescale readback", rd, 32'h00AB_CDEF);
    busWr(6'd36, 32'h0);

    // table walk: R3 R4 R5 R7 R8
    for (int v = 0; v < NVEC; v++) begin
      int ch, pre, per, duty;
      logic pol;
      ch = int'(VEC[v][40:39]); pol = VEC[v][38];
      pre = int'(VEC[v][37:32]); per = int'(VEC[v][31:16]); duty = int'(VEC[v][15:0]);
      progCh(ch, pre, per, duty);
      trig(ch, pol);
      watchWave(ch, pre, per, duty, pol, 0, 2*(pre+1)*per + 4,
                $sformatf("R4 R5 R7 table vector %0d", v));
    end

    // R6 staged values do not disturb a running channel
    progCh(0, 0, 4, 2);
    trig(0, 1'b1);
    watchWave(0, 0, 4, 2, 1'b1, 0, 16, "R4 before staging");
    busWr(6'd4, 32'd8);
    busWr(6'd8, 32'd8);
    watchWave(0, 0, 4, 2, 1'b1, 20, 16, "R6 counts staged");
    ctrlVal[8] = 1'b0;
    busWr(6'd0, ctrlVal);
    watchWave(0, 0, 4, 2, 1'b1, 38, 12, "R6 polarity staged");
    trig(0, 1'b1);
    watchWave(0, 0, 8, 8, 1'b1, 0, 20, "R5 R6 applied duty>=period");

    // R9 stopped channel
    ctrlVal[0] = 1'b0;
    busWr(6'd0, ctrlVal);
    @(negedge clk);
    errs = 0;
    for (int i = 0; i < 10; i++) begin
      @(negedge clk);
      if (pwmOut[0] !== 1'b0) errs++;
    end
    chk("R9 idle level", 32'(errs), 0);
    ctrlVal[8] = 1'b0;
    busWr(6'd0, ctrlVal);
    @(negedge clk);
    chk("R9 idle uses applied polarity", {31'd0, pwmOut[0]}, 32'd0);

    // R8 inverted polarity
    progCh(0, 0, 4, 1);
    trig(0, 1'b0);
    watchWave(0, 0, 4, 1, 1'b0, 0, 16, "R8 inverted");

    // R10 drive style
    progCh(1, 0, 4, 2);
    trig(1, 1'b1);
    ctrlVal[16] = 1'b1;
    busWr(6'd0, ctrlVal);
    errs = 0; seenHi = 1'b0; seenLo = 1'b0;
    for (int i = 0; i < 16; i++) begin
      @(negedge clk);
      if (pwmOe[1] !== ~pwmOut[1]) errs++;
      if (pwmOe[0] !== 1'b1) errs++;
      if (pwmOut[1] === 1'b1) seenHi = 1'b1;
      if (pwmOut[1] === 1'b0) seenLo = 1'b1;
    end
    chk("R10 output enable", 32'(errs), 0);
    chk("R10 both levels seen", {30'd0, seenHi, seenLo}, 32'd3);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule